// File: doc/BRIEF.md
# Audio Serial Transmitter with Bit-Clock and Word-Select Generation

This block turns pairs of parallel audio samples into a three-wire serial stream. It makes its own bit clock by dividing a source rate by a programmable amount. It then divides that bit clock into word-select slots of programmable length. The stream uses one of three bit alignments inside each slot. Stereo mode sends separate left and right words. Mono mode repeats one word in both slots.

Everything runs on the system clock. The second clock source arrives as a one-cycle strobe in the system clock domain, so the bit clock is a registered output and no clock mux is needed. When the run bit is cleared, every counter and output returns to zero. Setting run again starts a new frame at the left slot.

Each time word select rises, the block raises a one-cycle trigger for a downstream converter. An enable input gates this trigger. Sample pairs are accepted with a valid/ready handshake. Ready is a single-cycle strobe at each frame start.

Top module: `i2s_tx`

## Requirements
- R1: With the system clock as source, the bit clock holds each level for exactly bclk_div_i+1 cycles, so a divide value of 0 halves the system clock rate.
- R2: With clk_sel_i=1, the divider counts alt_tick_i strobes instead of system cycles, so each bit-clock level lasts (bclk_div_i+1) strobes.
- R3: While run_i is 0, the bit clock, word select, serial data, ready and trigger are all 0 within one cycle. After run_i rises, the first bit-clock falling edge begins a frame in the left slot at bit position 0.
- R4: Each word-select half lasts ws_div_i+1 bit periods. Word select and serial data change only in the cycle of a bit-clock falling edge.
- R5: With fmt_i=00 (11 behaves the same), word select is 0 for the left slot. Slot position 0 carries 0, positions 1 to SAMPLE_W carry the word MSB first, and later positions carry 0.
- R6: With fmt_i=01, word select is 1 for the left slot. The MSB is sent at slot position 0 and positions past the word carry 0.
- R7: With fmt_i=10, word select is 1 for the left slot. The LSB is sent at the last slot position (ws_div_i) and zeros pad the positions in front of the word.
- R8: With mono_i=1, the left word is sent in both slots and right_i has no effect on sd_o.
- R9: ready_o is high only in the cycle whose bit-clock falling edge starts a frame. The pair on left_i/right_i is taken when valid_i is also high. If valid_i is low at that point, the whole frame carries zeros.
- R10: trig_o is a one-cycle pulse in the first cycle that ws_o is 1 after being 0. It is raised only while trig_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run enable; 0 stops and clears all counters |
| clk_sel_i | input | 1 | Divider source: 0 system clock, 1 alternate strobe |
| alt_tick_i | input | 1 | One-cycle strobe that marks the alternate source rate |
| bclk_div_i | input | DIV_W | Bit-clock divide value (half period minus one) |
| ws_div_i | input | SLOT_W | Slot length in bit periods minus one |
| fmt_i | input | 2 | Alignment: 00 standard delayed, 01 left-aligned, 10 right-aligned |
| mono_i | input | 1 | 1 repeats the left word in both slots |
| trig_en_i | input | 1 | Enables the trigger pulse |
| left_i | input | SAMPLE_W | Left sample |
| right_i | input | SAMPLE_W | Right sample |
| valid_i | input | 1 | Sample pair valid |
| ready_o | output | 1 | Sample pair accepted at frame start |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| trig_o | output | 1 | Trigger pulse on word-select rise |

## Verification
The embedded properties check, on every cycle, the behaviour that is local to each piece of logic. They cover clearing while stopped, the bit clock holding between source ticks, a bit-clock fall always driving the clock low, word select moving only on a fall, ready coinciding with a fall that lands on left position 0, and the trigger following a word-select rise as a single pulse. Only the bench's sweeps can show the rest. That includes the exact bit placement for each alignment and slot length, mono repetition, zero fill on a missed handshake, the measured half periods from both sources, and clean restart after run is dropped part-way through a frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   typedef enum logic [1:0] {
      FMT_STD   = 2'b00,
      FMT_LEFT  = 2'b01,
      FMT_RIGHT = 2'b10,
      FMT_RSVD  = 2'b11
   } fmt_e;

   // Word-select level that marks the left slot for a given alignment
   function automatic logic left_ws_level(input fmt_e f);
      return (f == FMT_LEFT) || (f == FMT_RIGHT);
   endfunction

endpackage

// File: rtl/i2s_tx_bclk_gen.sv
module i2s_tx_bclk_gen #(
   parameter int DIV_W   = 8,
   parameter bit ALT_SRC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sel,
   input  logic             alt_tick,
   input  logic [DIV_W-1:0] div,
   output logic             bclk,
   output logic             fall_ev
);

   logic             tick;
   logic [DIV_W-1:0] cnt_q;
   logic             bclk_q;
   logic             wrap;

   generate
      if (ALT_SRC) begin : g_src_sel
         assign tick = sel ? alt_tick : 1'b1;
      end else begin : g_src_sys
         logic unused_src;
         assign unused_src = sel ^ alt_tick;
         assign tick = 1'b1;
      end
   endgenerate

   assign wrap    = tick && (cnt_q >= div);
   assign fall_ev = run && wrap && bclk_q;
   assign bclk    = bclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (tick) begin
         if (cnt_q >= div) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0) && !bclk_q);

   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(bclk_q));

   p_fall_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev |=> !bclk_q);

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer #(
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              fall_ev,
   input  logic [SLOT_W-1:0] ws_div,
   input  logic              left_hi,
   output logic [SLOT_W-1:0] nxt_pos,
   output logic              nxt_half,
   output logic              frame_start,
   output logic              ws
);

   logic [SLOT_W-1:0] pos_q;
   logic              half_q;
   logic              primed_q;
   logic              ws_q;

   always_comb begin
      if (!primed_q) begin
         nxt_pos  = '0;
         nxt_half = 1'b0;
      end else if (pos_q >= ws_div) begin
         nxt_pos  = '0;
         nxt_half = ~half_q;
      end else begin
         nxt_pos  = pos_q + 1'b1;
         nxt_half = half_q;
      end
   end

   assign frame_start = fall_ev && (nxt_pos == '0) && !nxt_half;
   assign ws          = ws_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pos_q    <= '0;
         half_q   <= 1'b0;
         primed_q <= 1'b0;
         ws_q     <= 1'b0;
      end else if (fall_ev) begin
         pos_q    <= nxt_pos;
         half_q   <= nxt_half;
         primed_q <= 1'b1;
         ws_q     <= nxt_half ? ~left_hi : left_hi;
      end
   end

   p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !fall_ev) |=> $stable(ws_q));

   p_frame_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (pos_q == '0) && !half_q && primed_q);

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
   import i2s_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SLOT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                fall_ev,
   input  logic                frame_start,
   input  logic [SLOT_W-1:0]   nxt_pos,
   input  logic                nxt_half,
   input  logic [SLOT_W-1:0]   ws_div,
   input  fmt_e                fmt,
   input  logic                mono,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   input  logic                valid,
   output logic                ready,
   output logic                sd
);

   logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
   logic [SAMPLE_W-1:0] cur_l, cur_r, word;
   logic [SAMPLE_W-1:0] shifted;
   logic                bit_v;
   logic                sd_q;

   assign ready = frame_start;
   assign cur_l = frame_start ? (valid ? left_in  : '0) : hold_l_q;
   assign cur_r = frame_start ? (valid ? right_in : '0) : hold_r_q;
   assign word  = (mono || !nxt_half) ? cur_l : cur_r;

   always_comb begin
      int p;
      int k;
      p       = int'(nxt_pos);
      k       = 0;
      bit_v   = 1'b0;
      shifted = '0;
      unique case (fmt)
         FMT_LEFT: begin
            if (p < SAMPLE_W) begin
               shifted = word >> (SAMPLE_W - 1 - p);
               bit_v   = shifted[0];
            end
         end
         FMT_RIGHT: begin
            k = int'(ws_div) - p;
            if (k >= 0 && k < SAMPLE_W) begin
               shifted = word >> k;
               bit_v   = shifted[0];
            end
         end
         default: begin
            if (p >= 1 && p <= SAMPLE_W) begin
               shifted = word >> (SAMPLE_W - p);
               bit_v   = shifted[0];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         hold_l_q <= '0;
         hold_r_q <= '0;
         sd_q     <= 1'b0;
      end else begin
         if (frame_start) begin
            hold_l_q <= cur_l;
            hold_r_q <= cur_r;
         end
         if (fall_ev) begin
            sd_q <= bit_v;
         end
      end
   end

   assign sd = sd_q;

   p_sd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sd_q);

   p_ready_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> fall_ev);

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
   import i2s_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DIV_W    = 8,
   parameter int SLOT_W   = 6,
   parameter bit ALT_SRC  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_i,
   input  logic                clk_sel_i,
   input  logic                alt_tick_i,
   input  logic [DIV_W-1:0]    bclk_div_i,
   input  logic [SLOT_W-1:0]   ws_div_i,
   input  logic [1:0]          fmt_i,
   input  logic                mono_i,
   input  logic                trig_en_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   input  logic                valid_i,
   output logic                ready_o,
   output logic                bclk_o,
   output logic                ws_o,
   output logic                sd_o,
   output logic                trig_o
);

   localparam int MAX_SLOT = 1 << SLOT_W;

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > MAX_SLOT) begin : g_bad_sample_w
         $error("SAMPLE_W must lie between 1 and the largest slot length");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
         $error("DIV_W must lie between 1 and 16");
      end
      if (SLOT_W < 1 || SLOT_W > 8) begin : g_bad_slot_w
         $error("SLOT_W must lie between 1 and 8");
      end
   endgenerate

   fmt_e              fmt;
   logic              left_hi;
   logic              fall_ev;
   logic [SLOT_W-1:0] nxt_pos;
   logic              nxt_half;
   logic              frame_start;
   logic              ws_d_q;

   assign fmt     = fmt_e'(fmt_i);
   assign left_hi = left_ws_level(fmt);

   i2s_tx_bclk_gen #(
      .DIV_W   (DIV_W),
      .ALT_SRC (ALT_SRC)
   ) u_bclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_i),
      .sel      (clk_sel_i),
      .alt_tick (alt_tick_i),
      .div      (bclk_div_i),
      .bclk     (bclk_o),
      .fall_ev  (fall_ev)
   );

   i2s_tx_framer #(
      .SLOT_W (SLOT_W)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_i),
      .fall_ev     (fall_ev),
      .ws_div      (ws_div_i),
      .left_hi     (left_hi),
      .nxt_pos     (nxt_pos),
      .nxt_half    (nxt_half),
      .frame_start (frame_start),
      .ws          (ws_o)
   );

   i2s_tx_serializer #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_i),
      .fall_ev     (fall_ev),
      .frame_start (frame_start),
      .nxt_pos     (nxt_pos),
      .nxt_half    (nxt_half),
      .ws_div      (ws_div_i),
      .fmt         (fmt),
      .mono        (mono_i),
      .left_in     (left_i),
      .right_in    (right_i),
      .valid       (valid_i),
      .ready       (ready_o),
      .sd          (sd_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_d_q <= 1'b0;
      end else begin
         ws_d_q <= ws_o;
      end
   end

   assign trig_o = trig_en_i && ws_o && !ws_d_q;

   p_trig_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   p_trig_after_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $rose(ws_o));

endmodule

// File: tb/i2s_tx_test.sv
module i2s_tx_test;

   localparam int CLK_P = 10;
   localparam int BW    = 8;
   localparam int DW    = 8;
   localparam int SW    = 6;
   localparam int WDOG  = 180000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_i = 1'b0;
   logic          clk_sel_i = 1'b0;
   logic          alt_tick_i = 1'b0;
   logic [DW-1:0] bclk_div_i = '0;
   logic [SW-1:0] ws_div_i = '0;
   logic [1:0]    fmt_i = '0;
   logic          mono_i = 1'b0;
   logic          trig_en_i = 1'b0;
   logic [BW-1:0] left_i, right_i;
   logic          valid_i = 1'b0;
   logic          ready_o, bclk_o, ws_o, sd_o, trig_o;

   i2s_tx #(.SAMPLE_W(BW), .DIV_W(DW), .SLOT_W(SW), .ALT_SRC(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .clk_sel_i(clk_sel_i),
      .alt_tick_i(alt_tick_i), .bclk_div_i(bclk_div_i), .ws_div_i(ws_div_i),
      .fmt_i(fmt_i), .mono_i(mono_i), .trig_en_i(trig_en_i),
      .left_i(left_i), .right_i(right_i), .valid_i(valid_i),
      .ready_o(ready_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .trig_o(trig_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   // sample source: advances once per accepted pair
   int fcnt = 0;
   int alt_cnt = 0;
   assign left_i  = BW'(8'hA5 ^ (fcnt * 37));
   assign right_i = BW'(8'h3C + (fcnt * 91));

   always @(posedge clk) begin
      if (ready_o && valid_i) fcnt <= fcnt + 1;
      alt_cnt    <= (alt_cnt == 2) ? 0 : alt_cnt + 1;
      alt_tick_i <= (alt_cnt == 2);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [BW-1:0] l, input logic [BW-1:0] r,
                                  input int h, input int p, input int s,
                                  input int f, input bit mono);
      logic [BW-1:0] w;
      logic [BW-1:0] t;
      int k;
      w = (mono || h == 0) ? l : r;
      t = '0;
      if (f == 1) begin
         if (p < BW) t = w >> (BW - 1 - p);
      end else if (f == 2) begin
         k = s - 1 - p;
         if (k < BW) t = w >> k;
      end else begin
         if (p >= 1 && p <= BW) t = w >> (BW - p);
      end
      return t[0];
   endfunction

   // monitor state
   bit            mon_on = 1'b0;
   bit            seen_edge;
   bit            pend_seen;
   int            since, nfall, exp_half, cfg_s;
   logic [BW-1:0] pend_l, pend_r, cur_l, cur_r;
   logic          bclk_prev = 1'b0, ws_prev = 1'b0;

   always @(negedge clk) begin
      int g, h, p;
      bit e_ws, e_sd, e_tr;
      string tag;
      cyc++;
      if (cyc > WDOG) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
      if (mon_on) begin
         since++;
         if (bclk_o != bclk_prev) begin
            if (seen_edge)
               chk(since == exp_half, clk_sel_i ? "R2 half period" : "R1 half period",
                   since, exp_half);
            seen_edge = 1'b1;
            since = 0;
            if (!bclk_o) begin
               g = nfall;
               h = (g / cfg_s) % 2;
               p = g % cfg_s;
               if (p == 0 && h == 0) begin
                  chk(pend_seen, "R9 ready before frame", pend_seen, 1);
                  cur_l = pend_l;
                  cur_r = pend_r;
                  pend_seen = 1'b0;
               end
               e_ws = (fmt_i == 2'b01 || fmt_i == 2'b10) ? (h == 0) : (h == 1);
               chk(ws_o == e_ws, "R4 word select", ws_o, e_ws);
               e_sd = exp_bit(cur_l, cur_r, h, p, cfg_s, fmt_i, mono_i);
               tag = (fmt_i == 2'b01) ? "R6 data" : (fmt_i == 2'b10) ? "R7 data" : "R5 data";
               if (mono_i) tag = {tag, " R8 mono"};
               chk(sd_o == e_sd, tag, sd_o, e_sd);
               nfall++;
            end
         end
         if ((ws_o != ws_prev) || trig_o) begin
            e_tr = trig_en_i && ws_o && !ws_prev;
            chk(trig_o == e_tr, "R10 trigger", trig_o, e_tr);
         end
         if (ready_o) begin
            chk((nfall % (2 * cfg_s) == 0) && bclk_o, "R9 ready at frame start",
                nfall % (2 * cfg_s), 0);
            pend_seen = 1'b1;
            pend_l = valid_i ? left_i  : '0;
            pend_r = valid_i ? right_i : '0;
         end
      end
      bclk_prev = bclk_o;
      ws_prev   = ws_o;
   end

   task automatic run_cfg(input int div, input int slot, input int fmt, input bit mono,
                          input bit sel, input bit ten, input bit vld);
      @(posedge clk); #1;
      bclk_div_i = DW'(div);
      ws_div_i   = SW'(slot - 1);
      fmt_i      = 2'(fmt);
      mono_i     = mono;
      clk_sel_i  = sel;
      trig_en_i  = ten;
      valid_i    = vld;
      cfg_s      = slot;
      exp_half   = (div + 1) * (sel ? 3 : 1);
      nfall      = 0;
      since      = 0;
      seen_edge  = 1'b0;
      pend_seen  = 1'b0;
      cur_l      = '0;
      cur_r      = '0;
      mon_on     = 1'b1;
      run_i      = 1'b1;
      // stop part-way into the third frame
      while (nfall < 4 * slot + 3) @(posedge clk);
      #1;
      run_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      mon_on = 1'b0;
      chk(!bclk_o && !ws_o && !sd_o && !trig_o && !ready_o, "R3 cleared when stopped",
          {bclk_o, ws_o, sd_o, trig_o, ready_o}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bclk_o && !ws_o && !sd_o && !trig_o && !ready_o, "R3 reset state",
          {bclk_o, ws_o, sd_o, trig_o, ready_o}, 0);

      for (int div = 0; div < 3; div++)
         for (int fmt = 0; fmt < 4; fmt++)
            for (int mono = 0; mono < 2; mono++)
               for (int si = 0; si < 2; si++)
                  run_cfg(div, si ? 12 : BW + 1, fmt, mono[0], 1'b0, (div != 1), 1'b1);

      // alternate source strobe
      run_cfg(0, 10, 1, 1'b0, 1'b1, 1'b1, 1'b1);
      run_cfg(1, 12, 0, 1'b0, 1'b1, 1'b1, 1'b1);
      // no valid data: zero frames
      run_cfg(0, 12, 2, 1'b0, 1'b0, 1'b1, 1'b0);
      run_cfg(1, 9, 0, 1'b1, 1'b0, 1'b0, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule